// File: doc/BRIEF.md
# Double-Buffered Output-Compare Value Register

This block holds the compare value that an output-compare channel matches against a free-running counter. Software writes a new value through a 16-bit bus port. Every accepted write goes into a shadow register first. The shadow is copied into the active compare register according to a selectable policy. The policy is either an immediate copy, a copy when the counter arrives at zero, or a copy when the counter arrives at its programmed top value. While the counter is halted, the copy happens on every cycle. Because of this, the active value is always current before the counter starts.

Reads return the active value, never the shadow. The buffering policy is captured only while the channel is disabled, so a running channel cannot change how it reloads. Buffered reloads let software update several channels at any time during a counter period and have all of them switch together at the same counter event.

The block sits next to the counter and the match comparator. It does not include either of them.

Top module: `cmpbuf_top`

## Requirements
- R1: After synchronous reset, the active and shadow values are 0x0000, buffering is enabled and the zero-arrival policy is selected.
- R2: A write with `bus_wide` = 0 (a byte-sized access) changes neither the shadow nor the active value.
- R3: With buffering disabled (`cfg_direct` = 1), a full-width write at clock edge k appears on `cmp_value` after edge k+1, whatever the counter does.
- R4: With buffering enabled and `cfg_on_peak` = 0, the shadow is copied at the edge where `cnt_value` first becomes 0x0000. No other counter value causes a copy.
- R5: With buffering enabled and `cfg_on_peak` = 1, the shadow is copied at the edge where `cnt_value` first equals `cnt_top`. Arrival at zero causes no copy.
- R6: While `cnt_halted` = 1, the shadow is copied into the active register on every edge, whatever the policy.
- R7: `bus_rdata` always equals the active value and never shows a pending shadow value.
- R8: While buffering is disabled, the value of `cfg_on_peak` has no effect on when copies happen.
- R9: `cfg_direct` and `cfg_on_peak` are captured only on edges where `ch_enable` = 0. Changes made while `ch_enable` = 1 are ignored.
- R10: If a write and a copy fall on the same edge, the active register takes the shadow value from before the write. The new value waits for the next copy.
- R11: The counter may rest on the target value for several cycles. That stay causes a single copy, and writes made during the stay are not copied until the next arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 = full 16-bit access, 0 = byte access (rejected) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Readback: the active compare value |
| ch_enable | input | 1 | Channel enabled; freezes the policy settings |
| cfg_direct | input | 1 | 1 = buffering disabled (immediate copy) |
| cfg_on_peak | input | 1 | 1 = copy at counter top, 0 = copy at counter zero |
| cnt_value | input | 16 | Current counter value |
| cnt_top | input | 16 | Counter top (period) value |
| cnt_halted | input | 1 | Counter is stopped |
| cmp_value | output | 16 | Active compare value for the comparator |

## Verification
Most internal faults show up at the ports as the wrong value, or the right value at the wrong edge. A wrong policy register or a lost arrival strobe leaves `cmp_value` stuck on the previous value until the next counter period. A strobe that repeats while the counter rests on the target shows a mid-stay write one arrival too early. A shadow that accepts byte writes, or a copy that sees the post-write data, changes `cmp_value` exactly one edge after the offending cycle. The bench therefore compares `cmp_value` and `bus_rdata` against an expected value on every single cycle. It runs through halted, zero, top, direct and frozen-configuration phases.

// File: rtl/cmpbuf_pkg.sv
// Package: shared types for the double-buffered compare register.
// Assumes: nothing beyond SystemVerilog packed types.
package cmpbuf_pkg;

    // Reload policy resolved from the captured configuration bits.
    typedef enum logic [1:0] {
        XFER_IMMEDIATE = 2'd0,
        XFER_AT_ZERO   = 2'd1,
        XFER_AT_TOP    = 2'd2
    } xfer_mode_t;

    // Captured configuration bits.
    typedef struct packed {
        logic direct;
        logic on_peak;
    } xfer_cfg_t;

endpackage

// File: rtl/cmpbuf_cfg.sv
// Module: cmpbuf_cfg
// Captures the buffering policy while the channel is disabled and holds it
// frozen while the channel is enabled. Resolves the bits to a reload mode.
// Assumes: the configuration inputs are synchronous to clk.
module cmpbuf_cfg
    import cmpbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ch_enable,
    input  logic       req_direct,
    input  logic       req_on_peak,
    output xfer_mode_t mode
);

    xfer_cfg_t cfg_q;

    // Capture the policy bits only while the channel is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{direct: 1'b0, on_peak: 1'b0};
        end else if (!ch_enable) begin
            cfg_q <= '{direct: req_direct, on_peak: req_on_peak};
        end
    end

    // Resolve the policy; the top-versus-zero choice only matters when buffered.
    always_comb begin
        if (cfg_q.direct)       mode = XFER_IMMEDIATE;
        else if (cfg_q.on_peak) mode = XFER_AT_TOP;
        else                    mode = XFER_AT_ZERO;
    end

    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ch_enable |=> $stable(cfg_q));

endmodule

// File: rtl/cmpbuf_evt.sv
// Module: cmpbuf_evt
// Produces a single-cycle strobe when the counter arrives at the reload
// target (zero or top, chosen by the mode). A stay on the target yields one strobe.
// Assumes: the counter value and top are synchronous to clk.
module cmpbuf_evt
    import cmpbuf_pkg::*;
#(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  xfer_mode_t   mode,
    input  logic [W-1:0] cnt_value,
    input  logic [W-1:0] cnt_top,
    output logic         arrive
);

    localparam logic [W-1:0] ZERO = '0;

    logic on_target;
    logic on_target_q;

    // Select which counter value counts as the reload point.
    always_comb begin
        if (mode == XFER_AT_TOP) on_target = (cnt_value == cnt_top);
        else                     on_target = (cnt_value == ZERO);
    end

    // Remember last cycle's target state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) on_target_q <= 1'b0;
        else        on_target_q <= on_target;
    end

    // Strobe only on the first cycle at the target.
    always_comb arrive = on_target & ~on_target_q;

    // R11
    arrive_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arrive |=> !arrive);

endmodule

// File: rtl/cmpbuf_regs.sv
// Module: cmpbuf_regs
// Holds the shadow and active compare registers. A load copies the shadow
// as it was before any write on the same edge.
// Assumes: load and write_ok are single-clock qualified strobes.
module cmpbuf_regs #(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         write_ok,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);

    // Shadow register: takes every accepted full-width write.
    always_ff @(posedge clk) begin
        if (!rst_n)        shadow <= '0;
        else if (write_ok) shadow <= wdata;
    end

    // Active register: takes the pre-write shadow when a load is due.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= '0;
        else if (load) active <= shadow;
    end

    // R10
    load_old_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (active == $past(shadow)));

    // R4
    hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(active));

endmodule

// File: rtl/cmpbuf_top.sv
// Module: cmpbuf_top
// Double-buffered compare value register. Writes land in a shadow; the
// shadow reaches the active value immediately, at counter zero or at counter
// top, and on every cycle while the counter is halted.
// Assumes: only full-width writes are legal; byte writes are dropped.
module cmpbuf_top
    import cmpbuf_pkg::*;
#(
    parameter int W = 16
)(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_we,
    input  logic         bus_wide,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         ch_enable,
    input  logic         cfg_direct,
    input  logic         cfg_on_peak,
    input  logic [W-1:0] cnt_value,
    input  logic [W-1:0] cnt_top,
    input  logic         cnt_halted,
    output logic [W-1:0] cmp_value
);

    xfer_mode_t   mode;
    logic         arrive;
    logic         load;
    logic         write_ok;
    logic [W-1:0] shadow;
    logic [W-1:0] active;

    cmpbuf_cfg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .ch_enable   (ch_enable),
        .req_direct  (cfg_direct),
        .req_on_peak (cfg_on_peak),
        .mode        (mode)
    );

    cmpbuf_evt #(.W(W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .cnt_value (cnt_value),
        .cnt_top   (cnt_top),
        .arrive    (arrive)
    );

    // Accept only full-width writes; decide when the shadow moves across.
    always_comb begin
        write_ok = bus_we & bus_wide;
        load     = (mode == XFER_IMMEDIATE) | cnt_halted | arrive;
    end

    cmpbuf_regs #(.W(W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .write_ok (write_ok),
        .wdata    (bus_wdata),
        .load     (load),
        .shadow   (shadow),
        .active   (active)
    );

    // Both the comparator and the bus see the active value.
    always_comb begin
        cmp_value = active;
        bus_rdata = active;
    end

    // R2
    byte_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_wide) |=> $stable(shadow));

endmodule

// File: tb/tb_cmpbuf_top.sv
module tb_cmpbuf_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         bus_we, bus_wide, ch_enable, cfg_direct, cfg_on_peak, cnt_halted;
    logic [W-1:0] bus_wdata, cnt_value, cnt_top;
    logic [W-1:0] bus_rdata, cmp_value;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [W-1:0] exp;
        string        tag;
    } item_t;

    item_t sb_q[$];

    // Reference state, derived from the requirements.
    logic [W-1:0] m_shadow, m_active;
    logic         m_direct, m_peak, m_hitq;

    always #2.5 clk = ~clk;

    cmpbuf_top #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_enable(ch_enable),
        .cfg_direct(cfg_direct), .cfg_on_peak(cfg_on_peak),
        .cnt_value(cnt_value), .cnt_top(cnt_top), .cnt_halted(cnt_halted),
        .cmp_value(cmp_value)
    );

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: apply one cycle of stimulus and push the expected result.
    task automatic step(input logic rst, input logic we, input logic wide,
                        input logic [W-1:0] wd, input logic en, input logic dir,
                        input logic pk, input logic [W-1:0] cv,
                        input logic [W-1:0] top, input logic halt, input string tag);
        logic hit;
        @(negedge clk);
        rst_n = ~rst; bus_we = we; bus_wide = wide; bus_wdata = wd;
        ch_enable = en; cfg_direct = dir; cfg_on_peak = pk;
        cnt_value = cv; cnt_top = top; cnt_halted = halt;
        if (rst) begin
            m_shadow = '0; m_active = '0; m_direct = 1'b0; m_peak = 1'b0; m_hitq = 1'b0;
        end else begin
            hit = m_peak && !m_direct ? (cv == top) : (cv == '0);
            if (m_direct || halt || (hit && !m_hitq)) m_active = m_shadow;
            if (we && wide) m_shadow = wd;
            m_hitq = hit;
            if (!en) begin m_direct = dir; m_peak = pk; end
        end
        sb_q.push_back('{exp: m_active, tag: tag});
    endtask

    // Monitor: compare outputs shortly after each edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (cmp_value !== it.exp) begin
                errors++;
                $display("FAIL %s: cmp_value=%h expected=%h", it.tag, cmp_value, it.exp);
            end
            checks++;
            if (bus_rdata !== it.exp) begin
                errors++;
                $display("FAIL R7 (%s): bus_rdata=%h expected=%h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        // R1: reset with counter halted
        for (int i = 0; i < 3; i++)
            step(1, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R1");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R1");
        // R6: halted counter copies each cycle
        step(0, 1, 1, 16'h1234, 1, 0, 0, 16'd9, 16'd100, 1, "R6");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R6");
        // R2: byte write ignored, even while halted
        step(0, 1, 0, 16'hBEEF, 1, 0, 0, 16'd9, 16'd100, 1, "R2");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R2");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R2");
        // R4: zero-arrival policy (reset default, R1)
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd5, 16'd100, 0, "R4");
        step(0, 1, 1, 16'h2222, 1, 0, 0, 16'd6, 16'd100, 0, "R7");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd100, 16'd100, 0, "R4");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd0, 16'd100, 0, "R4");
        // R11: stay on zero, write during the stay waits
        step(0, 1, 1, 16'h3333, 1, 0, 0, 16'd0, 16'd100, 0, "R11");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd0, 16'd100, 0, "R11");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd0, 16'd100, 0, "R11");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd1, 16'd100, 0, "R11");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd0, 16'd100, 0, "R4");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd1, 16'd100, 0, "R4");
        // R5: top-arrival policy, set while disabled
        step(0, 0, 1, 16'h0, 0, 0, 1, 16'd2, 16'd100, 0, "R9");
        step(0, 1, 1, 16'h4444, 1, 0, 1, 16'd3, 16'd100, 0, "R5");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd0, 16'd100, 0, "R5");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd50, 16'd100, 0, "R5");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd100, 16'd100, 0, "R5");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd101, 16'd100, 0, "R5");
        // R9: config change while enabled is ignored
        step(0, 1, 1, 16'h5555, 1, 1, 0, 16'd3, 16'd100, 0, "R9");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd4, 16'd100, 0, "R9");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd0, 16'd100, 0, "R9");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd100, 16'd100, 0, "R9");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd7, 16'd100, 0, "R9");
        // R10: write on the same edge as a copy
        step(0, 1, 1, 16'h6666, 1, 0, 1, 16'd50, 16'd100, 0, "R10");
        step(0, 1, 1, 16'h7777, 1, 0, 1, 16'd100, 16'd100, 0, "R10");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd0, 16'd100, 0, "R10");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd100, 16'd100, 0, "R10");
        step(0, 0, 1, 16'h0, 1, 0, 1, 16'd20, 16'd100, 0, "R10");
        // R3: buffering disabled, copy one edge after the write
        step(0, 0, 1, 16'h0, 0, 1, 1, 16'd20, 16'd100, 0, "R3");
        step(0, 1, 1, 16'h8888, 1, 1, 1, 16'd37, 16'd100, 0, "R3");
        step(0, 0, 1, 16'h0, 1, 1, 1, 16'd38, 16'd100, 0, "R3");
        // R8: transfer-select ignored while unbuffered
        step(0, 0, 1, 16'h0, 0, 1, 0, 16'd39, 16'd100, 0, "R8");
        step(0, 1, 1, 16'h9999, 1, 1, 0, 16'd40, 16'd100, 0, "R8");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd41, 16'd100, 0, "R8");
        step(0, 1, 0, 16'hAAAA, 1, 1, 0, 16'd42, 16'd100, 0, "R2");
        step(0, 0, 1, 16'h0, 1, 1, 0, 16'd43, 16'd100, 0, "R2");
        // R1: reset again clears the value
        step(1, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R1");
        step(0, 0, 1, 16'h0, 1, 0, 0, 16'd9, 16'd100, 1, "R1");
        repeat (3) @(posedge clk);
        #2;
        finish_run();
    end

endmodule